// File: doc/BRIEF.md
# 64b/66b Block Decoder to Eight-Lane Media-Independent Word

This block turns one descrambled 66-bit line block into one 64-bit data word with eight per-lane control flags, the format used on a 10 Gb/s media-independent interface. Each 66-bit block is a 2-bit sync header plus a 64-bit payload. It is presented on a cycle where the clock enable is high. The decoded word appears on the registered outputs one clock edge later. The outputs hold their value through cycles where the enable is low.

A data header passes the payload through as eight data lanes. For a control header, the first payload byte selects the block type. The decoder then rebuilds where each lane sits: start and terminate lanes, ordered-set lanes, and control lanes whose 7-bit line codes are widened back to 8-bit control characters. A block whose header is invalid, or whose type is not a known value, becomes eight error characters. One of two strobes says which fault occurred. Block-type and control-code values match the usual 64b/66b encoder, so an encoder followed by this decoder returns its input unchanged. Descrambling and block alignment happen upstream.

Top module: `blk66_xgmii_decoder`

## Requirements
- R1: While reset is asserted and after it is released, until the first enabled block, every lane holds idle 0x07, all eight control flags are 1, and both error strobes are 0.
- R2: A block with header 2'b01 is data. Output lane i is payload bits [8i+7:8i], and all control flags are 0. The result appears one enabled clock edge after the block is presented.
- R3: The header value 2'b10 marks a control block, and payload byte 0 holds its type. For type 0x1E, lane i comes from the 7-bit code at payload bit 8+7i. The code map is: 0x00→0x07, 0x06→0x06, 0x1E→0xFE, 0x2D→0x1C, 0x33→0x3C, 0x4B→0x7C, 0x55→0xBC, 0x66→0xDC, 0x78→0xF7. Any other code gives 0xFE. All flags are 1.
- R4: Type 0x78 puts a start character 0xFB (control) in lane 0. Lanes 1–7 take payload bytes 1–7 as data (flags 8'h01).
- R5: Type 0x33 and type 0x2D decode lanes 0–3 from the codes at bit 8+7i and give lanes 5–7 payload bytes 5–7 as data (flags 8'h1F). Lane 4 is 0xFB for type 0x33. For type 0x2D, lane 4 is the ordered-set character chosen by payload bits [39:36].
- R6: The ordered-set nibble maps 0x0→0x9C and 0xF→0x5C, and any other value gives 0xFE. Three types use it:
  - Type 0x66: lane 0 is taken from bits [35:32], lanes 1–3 and 5–7 are payload data, and lane 4 is 0xFB (flags 8'h11).
  - Type 0x55: lane 0 is taken from bits [35:32], lane 4 from bits [39:36], and the other lanes are data (flags 8'h11).
  - Type 0x4B: lane 0 is taken from bits [35:32], lanes 1–3 are data, and lanes 4–7 come from the codes at bit 8+7i (flags 8'hF1).
- R7: The terminate types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF put the terminate character 0xFD in lane k = 0..7 respectively. Lanes below k carry payload byte i+1 as data. Lanes above k come from the codes at bit 8+7i. The flags are 8'hFF shifted left by k.
- R8: A header of 2'b00 or 2'b11 yields 0xFE in all lanes with all flags 1. `hdrErr` is high for exactly the one cycle after that edge, and `typeErr` stays low.
- R9: A control header with any other type byte yields 0xFE in all lanes with all flags 1. `typeErr` is high for exactly the one cycle after that edge, and `hdrErr` stays low.
- R10: On an edge where the enable is low, data and flags keep their values whatever the inputs are, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkValid | input | 1 | Clock enable: a block is presented this cycle |
| blkHdr | input | 2 | Sync header of the block |
| blkPayload | input | 64 | Descrambled block payload, type byte in bits [7:0] |
| xgData | output | 64 | Decoded lanes, lane i in bits [8i+7:8i] |
| xgCtrl | output | 8 | Per-lane control flag, bit i for lane i |
| hdrErr | output | 1 | One-cycle strobe: previous block had an invalid header |
| typeErr | output | 1 | One-cycle strobe: previous block had an unknown type |

## Verification
The hardest cases to reach from the ports are the terminate blocks. In these, a lane's role depends on its position relative to k, and data bytes come from a payload byte shifted by one. The stimulus builds each of the eight terminate types in a loop. Every lane gets a distinct data value, and a non-idle code is placed in the highest control field, so a lane shifted by one position or a wrong flag mask shows up as a mismatch. Error strobes are sampled in the cycle right after the bad block, and again one disabled cycle later, to confirm both that the pulse appears and that it lasts only one cycle.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;

  localparam int LANES    = 8;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 7;
  localparam int NIB_W    = 4;
  localparam int HDR_W    = 2;
  localparam int PAY_W    = LANES * BYTE_W;
  localparam int CODE_LSB = BYTE_W;
  localparam int LO_NIB   = 4 * BYTE_W;
  localparam int HI_NIB   = LO_NIB + NIB_W;
  localparam int HALF     = LANES / 2;

  localparam logic [HDR_W-1:0] SYNC_DATA = 2'b01;
  localparam logic [HDR_W-1:0] SYNC_CTRL = 2'b10;

  localparam logic [7:0] BT_ALLCTL  = 8'h1E;
  localparam logic [7:0] BT_OSHI    = 8'h2D;
  localparam logic [7:0] BT_STARTHI = 8'h33;
  localparam logic [7:0] BT_OSLO_ST = 8'h66;
  localparam logic [7:0] BT_OSBOTH  = 8'h55;
  localparam logic [7:0] BT_STARTLO = 8'h78;
  localparam logic [7:0] BT_OSLO    = 8'h4B;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERROR = 8'hFE;
  localparam logic [7:0] CH_SEQ   = 8'h9C;
  localparam logic [7:0] CH_SIG   = 8'h5C;

  typedef struct packed {
    logic       dataBlk;
    logic       allCtrl;
    logic       start0;
    logic       start4;
    logic       os4;
    logic       osStart;
    logic       os04;
    logic       os0;
    logic       termEn;
    logic [2:0] termLane;
    logic       badHdr;
    logic       badType;
  } blkCmd_t;

  function automatic logic [7:0] codeToChar(input logic [CODE_W-1:0] code);
    logic [7:0] ch;
    case (code)
      7'h00:   ch = CH_IDLE;
      7'h06:   ch = 8'h06;
      7'h1E:   ch = CH_ERROR;
      7'h2D:   ch = 8'h1C;
      7'h33:   ch = 8'h3C;
      7'h4B:   ch = 8'h7C;
      7'h55:   ch = 8'hBC;
      7'h66:   ch = 8'hDC;
      7'h78:   ch = 8'hF7;
      default: ch = CH_ERROR;
    endcase
    return ch;
  endfunction

  function automatic logic [7:0] nibToOs(input logic [NIB_W-1:0] nib);
    logic [7:0] ch;
    case (nib)
      4'h0:    ch = CH_SEQ;
      4'hF:    ch = CH_SIG;
      default: ch = CH_ERROR;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/blkdec_ctrl.sv
module blkdec_ctrl
  import blkdec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [HDR_W-1:0] blkHdr,
  input  logic [7:0]       blkType,
  output blkCmd_t          cmd,
  output logic             hdrErr,
  output logic             typeErr
);

  always_comb begin
    cmd = '0;
    if (blkHdr == SYNC_DATA) begin
      cmd.dataBlk = 1'b1;
    end else if (blkHdr == SYNC_CTRL) begin
      case (blkType)
        BT_ALLCTL:  cmd.allCtrl = 1'b1;
        BT_STARTLO: cmd.start0  = 1'b1;
        BT_STARTHI: cmd.start4  = 1'b1;
        BT_OSHI:    cmd.os4     = 1'b1;
        BT_OSLO_ST: cmd.osStart = 1'b1;
        BT_OSBOTH:  cmd.os04    = 1'b1;
        BT_OSLO:    cmd.os0     = 1'b1;
        8'h87: begin cmd.termEn = 1'b1; cmd.termLane = 3'd0; end
        8'h99: begin cmd.termEn = 1'b1; cmd.termLane = 3'd1; end
        8'hAA: begin cmd.termEn = 1'b1; cmd.termLane = 3'd2; end
        8'hB4: begin cmd.termEn = 1'b1; cmd.termLane = 3'd3; end
        8'hCC: begin cmd.termEn = 1'b1; cmd.termLane = 3'd4; end
        8'hD2: begin cmd.termEn = 1'b1; cmd.termLane = 3'd5; end
        8'hE1: begin cmd.termEn = 1'b1; cmd.termLane = 3'd6; end
        8'hFF: begin cmd.termEn = 1'b1; cmd.termLane = 3'd7; end
        default: cmd.badType = 1'b1;
      endcase
    end else begin
      cmd.badHdr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrErr  <= 1'b0;
      typeErr <= 1'b0;
    end else begin
      hdrErr  <= enable & cmd.badHdr;
      typeErr <= enable & cmd.badType;
    end
  end

  // R8 / R9: the two fault strobes never fire together
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrErr && typeErr));

  // R10: a disabled edge clears both strobes
  a_r10_strobes_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hdrErr && !typeErr));

  // R8: an invalid header presented with enable raises the header strobe next cycle
  a_r8_hdr_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (blkHdr == 2'b00 || blkHdr == 2'b11)) |=> (hdrErr && !typeErr));

endmodule

// File: rtl/blkdec_lanes.sv
module blkdec_lanes
  import blkdec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [PAY_W-1:0] payload,
  input  blkCmd_t          cmd,
  output logic [PAY_W-1:0] xgData,
  output logic [LANES-1:0] xgCtrl
);

  logic [PAY_W-1:0] nextData;
  logic [LANES-1:0] nextCtrl;
  logic             lane0Os;
  logic             framed;
  logic [7:0]       loOs;
  logic [7:0]       hiOs;

  assign lane0Os = cmd.osStart | cmd.os04 | cmd.os0;
  assign framed  = cmd.start0 | cmd.start4 | cmd.os4 | lane0Os;
  assign loOs    = nibToOs(payload[LO_NIB +: NIB_W]);
  assign hiOs    = nibToOs(payload[HI_NIB +: NIB_W]);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int         NI = (gi < LANES - 1) ? gi + 1 : gi;
    localparam logic [2:0] LI = 3'(gi);

    logic [7:0] sameB;
    logic [7:0] nextB;
    logic [7:0] codeC;
    logic [7:0] laneB;
    logic       laneC;

    assign sameB = payload[BYTE_W*gi +: BYTE_W];
    assign nextB = payload[BYTE_W*NI +: BYTE_W];
    assign codeC = codeToChar(payload[CODE_LSB + CODE_W*gi +: CODE_W]);

    always_comb begin
      laneB = CH_ERROR;
      laneC = 1'b1;
      if (cmd.dataBlk) begin
        laneB = sameB;
        laneC = 1'b0;
      end else if (cmd.allCtrl) begin
        laneB = codeC;
      end else if (cmd.termEn) begin
        if (LI < cmd.termLane) begin
          laneB = nextB;
          laneC = 1'b0;
        end else if (LI == cmd.termLane) begin
          laneB = CH_TERM;
        end else begin
          laneB = codeC;
        end
      end else if (framed) begin
        if (gi == 0) begin
          if (cmd.start0)    laneB = CH_START;
          else if (lane0Os)  laneB = loOs;
          else               laneB = codeC;
        end else if (gi < HALF) begin
          if (cmd.start0 | lane0Os) begin
            laneB = sameB;
            laneC = 1'b0;
          end else begin
            laneB = codeC;
          end
        end else if (gi == HALF) begin
          if (cmd.start0) begin
            laneB = sameB;
            laneC = 1'b0;
          end else if (cmd.start4 | cmd.osStart) begin
            laneB = CH_START;
          end else if (cmd.os4 | cmd.os04) begin
            laneB = hiOs;
          end else begin
            laneB = codeC;
          end
        end else begin
          if (cmd.os0) begin
            laneB = codeC;
          end else begin
            laneB = sameB;
            laneC = 1'b0;
          end
        end
      end
    end

    assign nextData[BYTE_W*gi +: BYTE_W] = laneB;
    assign nextCtrl[gi]                  = laneC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xgData <= {LANES{CH_IDLE}};
      xgCtrl <= '1;
    end else if (enable) begin
      xgData <= nextData;
      xgCtrl <= nextCtrl;
    end
  end

  // R2: an enabled data block arrives unchanged with all flags clear
  a_r2_data_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cmd.dataBlk) |=> (xgCtrl == '0 && xgData == $past(payload)));

  // R10: a disabled edge leaves the lanes untouched
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(xgData) && $stable(xgCtrl)));

endmodule

// File: rtl/blk66_xgmii_decoder.sv
module blk66_xgmii_decoder
  import blkdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkValid,
  input  logic [1:0]  blkHdr,
  input  logic [63:0] blkPayload,
  output logic [63:0] xgData,
  output logic [7:0]  xgCtrl,
  output logic        hdrErr,
  output logic        typeErr
);

  blkCmd_t cmd;

  blkdec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (blkValid),
    .blkHdr  (blkHdr),
    .blkType (blkPayload[7:0]),
    .cmd     (cmd),
    .hdrErr  (hdrErr),
    .typeErr (typeErr)
  );

  blkdec_lanes u_lanes (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (blkValid),
    .payload (blkPayload),
    .cmd     (cmd),
    .xgData  (xgData),
    .xgCtrl  (xgCtrl)
  );

  // R8: the header strobe coincides with a full error word from the lane path
  a_r8_hdr_err_word: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |-> (xgCtrl == '1 && xgData == {LANES{CH_ERROR}}));

  // R9: the type strobe coincides with a full error word from the lane path
  a_r9_type_err_word: assert property (@(posedge clk) disable iff (!rstN)
    typeErr |-> (xgCtrl == '1 && xgData == {LANES{CH_ERROR}}));

endmodule

// File: tb/blk66_xgmii_decoder_tb.sv
module blk66_xgmii_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkValid = 1'b0;
  logic [1:0]  blkHdr = 2'b01;
  logic [63:0] blkPayload = '0;
  logic [63:0] xgData;
  logic [7:0]  xgCtrl;
  logic        hdrErr;
  logic        typeErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  blk66_xgmii_decoder u_dut (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkHdr(blkHdr),
    .blkPayload(blkPayload), .xgData(xgData), .xgCtrl(xgCtrl),
    .hdrErr(hdrErr), .typeErr(typeErr)
  );

  task automatic checkOut(input string req, input logic [63:0] expD,
                          input logic [7:0] expC, input logic expH, input logic expT);
    checks++;
    if (xgData !== expD || xgCtrl !== expC || hdrErr !== expH || typeErr !== expT) begin
      fails++;
      $display("FAIL %s: data=%h ctrl=%h hdrErr=%b typeErr=%b expected data=%h ctrl=%h hdrErr=%b typeErr=%b",
               req, xgData, xgCtrl, hdrErr, typeErr, expD, expC, expH, expT);
    end
  endtask

  // present one block for one enabled edge, then sample just after it
  task automatic sendBlock(input logic [1:0] h, input logic [63:0] p);
    @(negedge clk);
    blkHdr = h; blkPayload = p; blkValid = 1'b1;
    @(posedge clk); #1;
    blkValid = 1'b0;
  endtask

  function automatic logic [63:0] codesPay(input logic [7:0] typ, input logic [55:0] codes);
    return {codes, typ};
  endfunction

  task automatic testReset();
    checkOut("R1 reset", {8{8'h07}}, 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic testData();
    sendBlock(2'b01, 64'h8877665544332211);
    checkOut("R2 data a", 64'h8877665544332211, 8'h00, 1'b0, 1'b0);
    sendBlock(2'b01, 64'hFDFBFE0707FDFB9C);
    checkOut("R2 data ctrl-like bytes", 64'hFDFBFE0707FDFB9C, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic testAllCtrl();
    sendBlock(2'b10, codesPay(8'h1E, {7'h66, 7'h55, 7'h4B, 7'h33, 7'h2D, 7'h1E, 7'h06, 7'h00}));
    checkOut("R3 codes a", 64'hDCBC7C3C1CFE0607, 8'hFF, 1'b0, 1'b0);
    sendBlock(2'b10, codesPay(8'h1E, {7'h00, 7'h00, 7'h00, 7'h00, 7'h7F, 7'h01, 7'h00, 7'h78}));
    checkOut("R3 codes b unknown", 64'h07070707FEFE07F7, 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic testStart();
    sendBlock(2'b10, 64'hA7A6A5A4A3A2A178);
    checkOut("R4 start lane0", 64'hA7A6A5A4A3A2A1FB, 8'h01, 1'b0, 1'b0);
    sendBlock(2'b10, {24'hB7B6B5, 4'h0, 7'h00, 7'h06, 7'h00, 7'h00, 8'h33});
    checkOut("R5 start lane4", 64'hB7B6B5FB07060707, 8'h1F, 1'b0, 1'b0);
    sendBlock(2'b10, {24'hC7C6C5, 4'h0, 7'h00, 7'h00, 7'h1E, 7'h00, 8'h2D});
    checkOut("R5 os lane4", 64'hC7C6C59C0707FE07, 8'h1F, 1'b0, 1'b0);
  endtask

  task automatic testOrdered();
    sendBlock(2'b10, {24'hD7D6D5, 4'h0, 4'hF, 24'hD3D2D1, 8'h66});
    checkOut("R6 os0 plus start", 64'hD7D6D5FBD3D2D15C, 8'h11, 1'b0, 1'b0);
    sendBlock(2'b10, {24'hE7E6E5, 4'hF, 4'h0, 24'hE3E2E1, 8'h55});
    checkOut("R6 os both", 64'hE7E6E55CE3E2E19C, 8'h11, 1'b0, 1'b0);
    sendBlock(2'b10, {24'hE7E6E5, 4'h5, 4'h3, 24'hE3E2E1, 8'h55});
    checkOut("R6 os bad nibbles", 64'hE7E6E5FEE3E2E1FE, 8'h11, 1'b0, 1'b0);
    sendBlock(2'b10, {7'h78, 7'h00, 7'h06, 7'h00, 4'h0, 24'hF3F2F1, 8'h4B});
    checkOut("R6 os lane0 ctrl high", 64'hF7070607F3F2F19C, 8'hF1, 1'b0, 1'b0);
  endtask

  task automatic testTerm();
    for (int k = 0; k < 8; k++) begin
      logic [7:0]  typ;
      logic [63:0] pay;
      logic [63:0] expD;
      case (k)
        0: typ = 8'h87; 1: typ = 8'h99; 2: typ = 8'hAA; 3: typ = 8'hB4;
        4: typ = 8'hCC; 5: typ = 8'hD2; 6: typ = 8'hE1; default: typ = 8'hFF;
      endcase
      pay = '0;
      pay[7:0] = typ;
      for (int i = 0; i < k; i++) pay[8*(i+1) +: 8] = 8'h40 + 8'(i);
      if (k < 7) pay[57 +: 7] = 7'h1E;
      for (int i = 0; i < 8; i++) begin
        if (i < k)        expD[8*i +: 8] = 8'h40 + 8'(i);
        else if (i == k)  expD[8*i +: 8] = 8'hFD;
        else if (i == 7)  expD[8*i +: 8] = 8'hFE;
        else              expD[8*i +: 8] = 8'h07;
      end
      sendBlock(2'b10, pay);
      checkOut($sformatf("R7 terminate lane %0d", k), expD, 8'hFF << k, 1'b0, 1'b0);
    end
  endtask

  task automatic testBadHdr();
    sendBlock(2'b00, 64'h1122334455667788);
    checkOut("R8 header 00", {8{8'hFE}}, 8'hFF, 1'b1, 1'b0);
    @(posedge clk); #1;
    checkOut("R8 strobe one cycle", {8{8'hFE}}, 8'hFF, 1'b0, 1'b0);
    sendBlock(2'b11, 64'h0000000000000078);
    checkOut("R8 header 11", {8{8'hFE}}, 8'hFF, 1'b1, 1'b0);
  endtask

  task automatic testBadType();
    sendBlock(2'b01, 64'h0102030405060708);
    sendBlock(2'b10, 64'h0000000000000000);
    checkOut("R9 type 00", {8{8'hFE}}, 8'hFF, 1'b0, 1'b1);
    @(posedge clk); #1;
    checkOut("R9 strobe one cycle", {8{8'hFE}}, 8'hFF, 1'b0, 1'b0);
    sendBlock(2'b10, 64'h00000000000000C3);
    checkOut("R9 type C3", {8{8'hFE}}, 8'hFF, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    sendBlock(2'b01, 64'hCAFEF00D12345678);
    @(negedge clk);
    blkValid = 1'b0; blkHdr = 2'b00; blkPayload = 64'h0;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R10 hold on bad header", 64'hCAFEF00D12345678, 8'h00, 1'b0, 1'b0);
    blkHdr = 2'b10; blkPayload = 64'h00000000000000FF;
    repeat (2) @(posedge clk);
    #1;
    checkOut("R10 hold on terminate", 64'hCAFEF00D12345678, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 in reset", {8{8'h07}}, 8'hFF, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    testReset();
    testData();
    testAllCtrl();
    testStart();
    testOrdered();
    testTerm();
    testBadHdr();
    testBadType();
    testHold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule